// File: doc/BRIEF.md
# Page Descriptor Usage Bit Updater

After an address translation has produced a page descriptor, this block keeps that descriptor's history bits up to date. The history bits are the used flag, which records that the page has been touched, and the dirty flag, which records that the page has been written. The block takes four inputs: the current flags, the access direction, and the write-protect status gathered over every level of the translation walk. From these it chooses one of three actions on the descriptor in memory: leave it alone, store it with a single plain write, or update it with a locked read-modify-write.

The locked read-modify-write reads the descriptor again and ORs the new flags into the value that comes back. Bits that another bus master changed since the walk are therefore kept. The memory lock stays asserted from the read request until the write is acknowledged. The block then reports the resulting flags and gives a one-cycle completion pulse.

A table walker starts the block once for each translation that needs it. The walker supplies the descriptor address and the descriptor word it fetched, and waits for the completion pulse.

Top module: `pgdesc_hist_upd`

## Requirements
- R1: On a read (`is_write_i`=0) with the used flag clear, the block performs a locked read-modify-write that sets only the used bit (bit `USED_BIT`, default 3). This holds for any write-protect value, and the reported dirty flag equals the incoming one.
- R2: On a read with the used flag set, the block makes no memory access and reports both flags unchanged.
- R3: On a write to an unprotected page with both flags clear, the block makes exactly one unlocked plain write, of `desc_i` with the used bit and the dirty bit (bit `DIRTY_BIT`, default 4) set, and reports used=1, dirty=1.
- R4: On a write to an unprotected page with used clear and dirty set, the block performs a locked read-modify-write that sets the used bit, and reports used=1, dirty=1.
- R5: On a write to an unprotected page with used set and dirty clear, the block makes one unlocked plain write of `desc_i` with the dirty bit set, and reports used=1, dirty=1.
- R6: On a write to an unprotected page with both flags set, the block makes no memory access.
- R7: When `wprot_i` is 1, a write never sets the dirty bit. With used clear, it performs a locked read-modify-write that sets only the used bit. With used set, it makes no access. The reported dirty flag equals the incoming one.
- R8: During a locked read-modify-write, `mem_lock_o` is high from the read request until the write acknowledge. The written word is the read data ORed with the bits being set. All accesses use `desc_addr_i`.
- R9: A request strobe (`mem_rd_o` or `mem_wr_o`) stays high until it is acknowledged, and the two strobes are never high together. `done_o` is a one-cycle pulse that comes one cycle after the last acknowledge, or one cycle after the start when no access is needed.
- R10: A `start_i` that arrives while `busy_o` is high is ignored.
- R11: A synchronous reset returns the block to idle, with lock, strobes, `busy_o`, `done_o` and both reported flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start an update; sampled only while idle |
| is_write_i | input | 1 | Access direction: 1 write, 0 read |
| wprot_i | input | 1 | Write protection accumulated over the walk |
| used_i | input | 1 | Current used flag of the descriptor |
| dirty_i | input | 1 | Current dirty flag of the descriptor |
| desc_addr_i | input | ADDR_W | Descriptor address |
| desc_i | input | DATA_W | Descriptor word fetched by the walk |
| mem_rd_o | output | 1 | Read request strobe |
| mem_wr_o | output | 1 | Write request strobe |
| mem_lock_o | output | 1 | Bus lock during the read-modify-write |
| mem_addr_o | output | ADDR_W | Access address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data |
| mem_ack_i | input | 1 | Acknowledge of the pending request |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | One-cycle completion pulse |
| used_o | output | 1 | Resulting used flag |
| dirty_o | output | 1 | Resulting dirty flag |

## Verification
A wrong choice of action shows up at the memory port within a cycle or two of the start. The symptom is an extra strobe, a missing strobe, or a plain write where a locked sequence was expected. If the flags decoded from the inputs are wrong, `mem_wdata_o` has the wrong bits at the first write acknowledge. A merge that drops bits set by another master shows up in the same place. A stuck state is exposed by a done pulse that arrives off its one-cycle slot, or never, or by the lock staying high after completion.

// File: rtl/pgdesc_pkg.sv
package pgdesc_pkg;

    typedef enum logic [1:0] {
        UPD_NONE   = 2'd0,
        UPD_PLAIN  = 2'd1,
        UPD_LOCKED = 2'd2
    } upd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PWRITE = 3'd1,
        ST_LREAD  = 3'd2,
        ST_LWRITE = 3'd3,
        ST_FIN    = 3'd4
    } upd_state_e;

endpackage

// File: rtl/pgdesc_decide.sv
module pgdesc_decide
    import pgdesc_pkg::*;
(
    input  logic      is_write,
    input  logic      wprot,
    input  logic      used,
    input  logic      dirty,
    output upd_kind_e kind,
    output logic      set_used,
    output logic      set_dirty,
    output logic      new_used,
    output logic      new_dirty
);
    logic dirty_allowed;

    always_comb begin
        dirty_allowed = is_write && !wprot;
        set_used      = !used;
        set_dirty     = dirty_allowed && !dirty;
        new_used      = 1'b1;
        new_dirty     = dirty || dirty_allowed;

        if (!used) begin
            // first touch; a plain store is safe only when both flags move together
            if (dirty_allowed && !dirty) begin
                kind = UPD_PLAIN;
            end else begin
                kind = UPD_LOCKED;
            end
        end else if (set_dirty) begin
            kind = UPD_PLAIN;
        end else begin
            kind = UPD_NONE;
        end
    end
endmodule

// File: rtl/pgdesc_merge.sv
module pgdesc_merge #(
    parameter int DATA_W    = 32,
    parameter int USED_BIT  = 3,
    parameter int DIRTY_BIT = 4
) (
    input  logic [DATA_W-1:0] base,
    input  logic              set_used,
    input  logic              set_dirty,
    output logic [DATA_W-1:0] merged
);
    logic [DATA_W-1:0] used_mask;
    logic [DATA_W-1:0] dirty_mask;

    always_comb begin
        used_mask            = '0;
        dirty_mask           = '0;
        used_mask[USED_BIT]  = set_used;
        dirty_mask[DIRTY_BIT] = set_dirty;
        merged               = base | used_mask | dirty_mask;
    end
endmodule

// File: rtl/pgdesc_hist_upd.sv
module pgdesc_hist_upd
    import pgdesc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int USED_BIT  = 3,
    parameter int DIRTY_BIT = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              is_write_i,
    input  logic              wprot_i,
    input  logic              used_i,
    input  logic              dirty_i,
    input  logic [ADDR_W-1:0] desc_addr_i,
    input  logic [DATA_W-1:0] desc_i,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              mem_lock_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              used_o,
    output logic              dirty_o
);

    typedef struct packed {
        upd_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              set_used;
        logic              set_dirty;
        logic              used;
        logic              dirty;
    } upd_regs_t;

    upd_regs_t r_d, r_q;

    upd_kind_e         dec_kind;
    logic              dec_set_used, dec_set_dirty;
    logic              dec_new_used, dec_new_dirty;
    logic [DATA_W-1:0] plain_word;
    logic [DATA_W-1:0] rmw_word;

    pgdesc_decide i_decide (
        .is_write  (is_write_i),
        .wprot     (wprot_i),
        .used      (used_i),
        .dirty     (dirty_i),
        .kind      (dec_kind),
        .set_used  (dec_set_used),
        .set_dirty (dec_set_dirty),
        .new_used  (dec_new_used),
        .new_dirty (dec_new_dirty)
    );

    // word for a plain store: walk copy of the descriptor plus new flags
    pgdesc_merge #(
        .DATA_W    (DATA_W),
        .USED_BIT  (USED_BIT),
        .DIRTY_BIT (DIRTY_BIT)
    ) i_merge_plain (
        .base      (desc_i),
        .set_used  (dec_set_used),
        .set_dirty (dec_set_dirty),
        .merged    (plain_word)
    );

    // word for the locked write-back: fresh read data plus new flags
    pgdesc_merge #(
        .DATA_W    (DATA_W),
        .USED_BIT  (USED_BIT),
        .DIRTY_BIT (DIRTY_BIT)
    ) i_merge_rmw (
        .base      (mem_rdata_i),
        .set_used  (r_q.set_used),
        .set_dirty (r_q.set_dirty),
        .merged    (rmw_word)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.addr      = desc_addr_i;
                    r_d.set_used  = dec_set_used;
                    r_d.set_dirty = dec_set_dirty;
                    r_d.used      = dec_new_used;
                    r_d.dirty     = dec_new_dirty;
                    unique case (dec_kind)
                        UPD_PLAIN: begin
                            r_d.data = plain_word;
                            r_d.st   = ST_PWRITE;
                        end
                        UPD_LOCKED: begin
                            r_d.st = ST_LREAD;
                        end
                        default: begin
                            r_d.st = ST_FIN;
                        end
                    endcase
                end
            end
            ST_PWRITE: begin
                if (mem_ack_i) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_LREAD: begin
                if (mem_ack_i) begin
                    r_d.data = rmw_word;
                    r_d.st   = ST_LWRITE;
                end
            end
            ST_LWRITE: begin
                if (mem_ack_i) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: ST_IDLE, addr: '0, data: '0, set_used: 1'b0,
                     set_dirty: 1'b0, used: 1'b0, dirty: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd_o    = (r_q.st == ST_LREAD);
    assign mem_wr_o    = (r_q.st == ST_PWRITE) || (r_q.st == ST_LWRITE);
    assign mem_lock_o  = (r_q.st == ST_LREAD) || (r_q.st == ST_LWRITE);
    assign mem_addr_o  = r_q.addr;
    assign mem_wdata_o = r_q.data;
    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = (r_q.st == ST_FIN);
    assign used_o      = r_q.used;
    assign dirty_o     = r_q.dirty;

endmodule

// File: rtl/pgdesc_hist_upd_chk.sv
module pgdesc_hist_upd_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic wprot_i,
    input logic dirty_i,
    input logic mem_rd_o,
    input logic mem_wr_o,
    input logic mem_lock_o,
    input logic mem_ack_i,
    input logic busy_o,
    input logic done_o,
    input logic used_o,
    input logic dirty_o
);
    // R8: a locked read is always under lock
    a_r8_read_locked: assert property (@(posedge clk) disable iff (rst)
        mem_rd_o |-> mem_lock_o);

    // R8: an acknowledged locked read is followed by the locked write-back
    a_r8_read_then_write: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && mem_ack_i) |=> (mem_wr_o && mem_lock_o));

    // R9: strobes are exclusive
    a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    // R9: requests held until acknowledged
    a_r9_hold_read: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_o && !mem_ack_i) |=> mem_rd_o);
    a_r9_hold_write: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_o && !mem_ack_i) |=> mem_wr_o);

    // R9: completion is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: protected accesses leave the dirty flag as it came in
    a_r7_wp_keeps_dirty: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && wprot_i) |=> (dirty_o == $past(dirty_i)));

    // R1: every accepted update reports the page as used
    a_r1_used_reported: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> used_o);

    // R10: a start during an update changes nothing reported
    a_r10_busy_ignores_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && busy_o) |=> ($stable(used_o) && $stable(dirty_o)));

    // R11: reset releases the bus and returns to idle
    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (!mem_lock_o && !busy_o && !done_o && !mem_rd_o && !mem_wr_o));
endmodule

bind pgdesc_hist_upd pgdesc_hist_upd_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .wprot_i    (wprot_i),
    .dirty_i    (dirty_i),
    .mem_rd_o   (mem_rd_o),
    .mem_wr_o   (mem_wr_o),
    .mem_lock_o (mem_lock_o),
    .mem_ack_i  (mem_ack_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .used_o     (used_o),
    .dirty_o    (dirty_o)
);

// File: tb/test_pgdesc_hist_upd.sv
module test_pgdesc_hist_upd;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int UB = 3;
    localparam int DB = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i, is_write_i, wprot_i, used_i, dirty_i;
    logic [AW-1:0] desc_addr_i;
    logic [DW-1:0] desc_i;
    logic          mem_rd_o, mem_wr_o, mem_lock_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_wdata_o;
    logic [DW-1:0] mem_rdata_i;
    logic          mem_ack_i;
    logic          busy_o, done_o, used_o, dirty_o;

    logic [DW-1:0] memword;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            finished = 0;

    always #5 clk = ~clk;
    assign mem_rdata_i = memword;

    pgdesc_hist_upd #(.ADDR_W(AW), .DATA_W(DW), .USED_BIT(UB), .DIRTY_BIT(DB)) i_pgdesc_hist_upd (
        .clk(clk), .rst(rst), .start_i(start_i), .is_write_i(is_write_i),
        .wprot_i(wprot_i), .used_i(used_i), .dirty_i(dirty_i),
        .desc_addr_i(desc_addr_i), .desc_i(desc_i),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_lock_o(mem_lock_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i),
        .busy_o(busy_o), .done_o(done_o), .used_o(used_o), .dirty_o(dirty_o)
    );

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // 0 none, 1 plain write, 2 locked read-modify-write
    function automatic int exp_kind(bit w, bit wp, bit u, bit m);
        if (!w || wp) return u ? 0 : 2;
        if (u && m) return 0;
        if (!u && m) return 2;
        return 1;
    endfunction

    function automatic string req_of(bit w, bit wp, bit u, bit m);
        if (!w) return u ? "R2" : "R1";
        if (wp) return "R7";
        case ({u, m})
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_op(bit w, bit wp, bit u, bit m, logic [DW-1:0] desc,
                          logic [DW-1:0] other, logic [AW-1:0] addr, bit disturb);
        int            reads = 0, writes = 0, ack_at = -1, done_at = -1;
        bit            lock_bad = 0, addr_bad = 0, wr_locked = 0;
        logic [DW-1:0] wdata = '0, pre, setmask, expw;
        int            kind = exp_kind(w, wp, u, m);
        string         rq = req_of(w, wp, u, m);

        memword = desc | other;
        pre     = memword;
        @(negedge clk);
        is_write_i = w; wprot_i = wp; used_i = u; dirty_i = m;
        desc_i = desc; desc_addr_i = addr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int cyc = 0; cyc < 100; cyc++) begin
            if (done_o) begin
                done_at = cyc;
                break;
            end
            mem_ack_i = 1'b0;
            if (disturb && cyc == 1) begin // R10: start while busy
                start_i = 1'b1; is_write_i = !w; wprot_i = !wp;
                used_i = !u; dirty_i = !m; desc_addr_i = ~addr;
            end
            if (mem_rd_o || mem_wr_o) begin
                if (mem_addr_o !== addr) addr_bad = 1;
                if (mem_rd_o && !mem_lock_o) lock_bad = 1;
                if ($urandom_range(2) != 0) begin
                    mem_ack_i = 1'b1;
                    ack_at = cyc;
                    if (mem_rd_o) reads++;
                    else begin
                        writes++;
                        wdata     = mem_wdata_o;
                        wr_locked = mem_lock_o;
                        memword   = mem_wdata_o;
                    end
                end
            end
            @(negedge clk);
            start_i = 1'b0;
        end
        mem_ack_i = 1'b0;

        setmask = '0;
        setmask[UB] = !u;
        setmask[DB] = w && !wp && !m;
        expw = ((kind == 1) ? desc : pre) | setmask;

        chk("R9", "done seen", done_at >= 0, 1);
        chk(rq, "read count", reads, (kind == 2) ? 1 : 0);
        chk(rq, "write count", writes, (kind != 0) ? 1 : 0);
        if (kind != 0) begin
            chk(rq, "written word", wdata, expw);
            chk("R8", "write lock", wr_locked, kind == 2);
            chk("R9", "done after last ack", done_at, ack_at + 1);
        end else begin
            chk("R9", "done after start", done_at, 0);
        end
        chk("R8", "address", addr_bad, 0);
        chk("R8", "read lock", lock_bad, 0);
        chk(rq, "used out", used_o, 1);
        chk(rq, "dirty out", dirty_o, m | (w & !wp));
        chk("R8", "lock released", mem_lock_o, 0);
        @(negedge clk);
        chk("R9", "done single pulse", done_o, 0);
        chk("R10", "idle after op", busy_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; start_i = 0; is_write_i = 0; wprot_i = 0; used_i = 0; dirty_i = 0;
        desc_addr_i = '0; desc_i = '0; mem_ack_i = 0; memword = '0;
        repeat (3) @(negedge clk);
        chk("R11", "reset busy", busy_o, 0);
        chk("R11", "reset lock", mem_lock_o, 0);
        chk("R11", "reset strobes", mem_rd_o | mem_wr_o, 0);
        chk("R11", "reset done", done_o, 0);
        chk("R11", "reset flags", {used_o, dirty_o}, 0);
        rst = 1'b0;

        // directed: every combination, with a foreign bit set in memory
        for (int i = 0; i < 16; i++) begin
            run_op(i[3], i[2], i[1], i[0], 32'h1234_5600, 32'h8000_0001,
                   32'h0000_1000 + 32'(i * 4), 1'b0);
        end
        // directed: busy restart on the locked path and the plain path
        run_op(1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h4000_0000, 32'hA0, 1'b1);
        run_op(1'b1, 1'b0, 1'b0, 1'b0, 32'hFF00, 32'h0, 32'hB0, 1'b1);

        // R11: reset in the middle of a locked sequence
        @(negedge clk);
        is_write_i = 0; wprot_i = 0; used_i = 0; dirty_i = 0;
        desc_addr_i = 32'hC0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R11", "locked read pending", mem_rd_o & mem_lock_o, 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", "mid-op reset lock", mem_lock_o, 0);
        chk("R11", "mid-op reset busy", busy_o, 0);
        chk("R11", "mid-op reset read", mem_rd_o, 0);

        // constrained random
        for (int n = 0; n < 300; n++) begin
            logic [DW-1:0] d = $urandom() & ~(32'h18);
            run_op(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
                   d, $urandom() & ~(32'h18), $urandom(), ($urandom_range(3) == 0));
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule